// File: doc/BRIEF.md
# SPI Master Transfer Engine with Event-Driven FIFOs

This block is a single-master SPI shift engine. Software reaches it through a small word-wide register port. Transmit words go into a transmit FIFO, and one word can carry an end-of-frame flag. A start command makes the engine pop words and shift them out on `mosi_o`. While each word goes out, the engine collects the bits that come back and pushes them as one word into a receive FIFO. The engine stops once the flagged word has fully shifted. Word length, bit order, clock polarity and clock phase are all programmable. An internal loopback path joins the transmit shift output to the receive input.

Every notable condition sets a sticky bit in an event register. These conditions are completion, FIFO level requests, FIFO overrun and underrun, and a multi-master fault. Writing one to an event bit clears it. A mask register selects which events drive the single interrupt line. The serial clock rate comes from an external divider, which delivers one pulse per SCLK half-period on `sclk_tick_i`. Chip-select generation is not part of this block.

Register map (3-bit word address):

| Address | Access | Contents |
|---------|--------|----------|
| 0 | write: push, read: pop | data word |
| 1 | read/write | configuration |
| 2 | write only | command |
| 3 | read only | status |
| 4 | read, write-one-to-clear | event |
| 5 | read/write | mask |

Top module: `spi_fifo_master`

## Requirements
- R1: Reset values. The event register reads 0 and the mask reads 0xFF. `irq_o` is 0 and SCLK idles low. The configuration register (address 1) reads 0x1E07. The status register (address 3) reads 0x4, with bit0 device-ready, bit1 TX full, bit2 RX empty and bit3 busy.
- R2: Configuration bits [4:0] hold the word length minus one. Written values below 3 are stored as 3, and values above 23 are stored as 23, which gives 4 to 24 bits per word. A received word reads from address 0 zero-extended to 32 bits.
- R3: Configuration bit 5 selects the bit order: 1 shifts LSB first and 0 shifts MSB first. The same order applies to transmit and to receive.
- R4: Configuration bit 6 is CPOL and sets the SCLK idle level. Configuration bit 7 is CPHA. With CPHA=0, data is sampled on the leading edge and changes on the trailing edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge.
- R5: A write to address 0 pushes bits [23:0] as data and bit 24 as the last-word flag. Once the flagged word has fully shifted, the engine stops with SCLK idle and sets event bit0 (done).
- R6: No SCLK edge occurs until the start command is given (address 2, bit0). A start is honoured only while the enable bit, configuration bit 13, is set; status bit0 reports that enable bit.
- R7: If the transmit FIFO is empty when a new word is needed and no flagged word has been sent, event bit6 is set. The engine then idles with SCLK at its idle level until the next start command, and then continues from the FIFO.
- R8: Writing 1 to an event bit clears it. A condition that is still present sets its bit again, and a set in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some event bit is set and its mask bit (address 5) is 0.
- R10: A word that completes while the receive FIFO is full is discarded and sets event bit3. Words already in the FIFO are kept unchanged.
- R11: Configuration bit 8 selects loopback. In loopback the receive input is the transmitted bit and `miso_i` is ignored.
- R12: Command bit1 empties the receive FIFO and command bit2 empties the transmit FIFO. Status bits 1 and 2 follow the FIFO levels.
- R13: While enabled, event bit1 is set when the receive FIFO holds at least `1<<cfg[12:11]` words. Event bit2 is set when the transmit FIFO has at least `1<<cfg[10:9]` free entries.
- R14: A push to a full transmit FIFO is dropped and sets event bit5. A read of an empty receive FIFO sets event bit4. A pulse on `mm_fault_i` during a transfer sets event bit7 and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe; pops the receive FIFO at address 0 |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt, unmasked events present |
| sclk_tick_i | input | 1 | Half-period pulse from the clock divider |
| mm_fault_i | input | 1 | Multi-master fault indication |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest states to reach are the ones where the two FIFOs are out of step with the shift engine.

- **Transmit underflow with resume.** The bench loads a single unflagged word and starts a transfer, so the transmit FIFO runs dry mid-frame. It then confirms that SCLK stays idle before adding the flagged word and restarting.
- **Receive overflow.** The bench queues sixteen words and starts the transfer. It then pushes a seventeenth, flagged word during the shift, which needs a free entry behind the first pop. This fills the receive FIFO so that the final word must be discarded.
- **Bit order and clock mode.** Each captured MOSI bit is compared on the slave's sampling edge against the order computed from the mode, word length and bit order.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned EV_N   = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVENT = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;

  localparam int unsigned EV_DONE   = 0;
  localparam int unsigned EV_RX_REQ = 1;
  localparam int unsigned EV_TX_REQ = 2;
  localparam int unsigned EV_RX_OVF = 3;
  localparam int unsigned EV_RX_UNF = 4;
  localparam int unsigned EV_TX_OVF = 5;
  localparam int unsigned EV_TX_UNF = 6;
  localparam int unsigned EV_MM     = 7;

  typedef enum logic {ST_IDLE, ST_RUN} sh_state_e;

  typedef struct packed {
    logic             en;
    logic [1:0]       rx_thr;
    logic [1:0]       tx_thr;
    logic             loop;
    logic             cpha;
    logic             cpol;
    logic             lsb;
    logic [LEN_W-1:0] len_m1;
  } cfg_t;

  function automatic logic [LEN_W-1:0] bit_pos(input logic [LEN_W-1:0] idx,
                                               input logic [LEN_W-1:0] len_m1,
                                               input logic lsb);
    return lsb ? idx : LEN_W'(len_m1 - idx);
  endfunction
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + AW'(1));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= data_i;
  end

  assert_hold_when_full_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
  assert_count_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              enable_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              lsb_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              loop_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tx_last_i,
  input  logic              miso_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              unf_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  sh_state_e         state_q;
  logic              half_q, last_q, mosi_q;
  logic [LEN_W-1:0]  idx_q;
  logic [DATA_W-1:0] cur_q, rx_acc_q, rx_next;
  logic              run, lead, trail, smp_now, smp_bit, last_bit;
  logic              load_first, load_next;

  assign run      = (state_q == ST_RUN) && !abort_i;
  assign lead     = run && tick_i && !half_q;
  assign trail    = run && tick_i && half_q;
  assign smp_now  = cpha_i ? trail : lead;
  assign smp_bit  = loop_i ? mosi_q : miso_i;
  assign last_bit = (idx_q == len_m1_i);

  assign load_first = (state_q == ST_IDLE) && start_i && enable_i && tx_valid_i;
  assign load_next  = trail && last_bit && !last_q && tx_valid_i;
  assign tx_pop_o   = load_first || load_next;

  always_comb begin
    rx_next = rx_acc_q;
    if (smp_now) rx_next[bit_pos(idx_q, len_m1_i, lsb_i)] = smp_bit;
  end

  assign busy_o = (state_q == ST_RUN);
  assign sclk_o = cpol_i ^ half_q;
  assign mosi_o = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      last_q    <= 1'b0;
      mosi_q    <= 1'b0;
      idx_q     <= '0;
      cur_q     <= '0;
      rx_acc_q  <= '0;
      rx_word_o <= '0;
      rx_push_o <= 1'b0;
      done_o    <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      rx_push_o <= 1'b0;
      done_o    <= 1'b0;
      unf_o     <= 1'b0;
      rx_acc_q  <= tx_pop_o ? '0 : rx_next;
      if (tx_pop_o) begin
        cur_q  <= tx_word_i;
        last_q <= tx_last_i;
        idx_q  <= '0;
        half_q <= 1'b0;
        state_q <= ST_RUN;
        if (!cpha_i) mosi_q <= tx_word_i[bit_pos('0, len_m1_i, lsb_i)];
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && enable_i && !tx_valid_i) unf_o <= 1'b1;
        end
        ST_RUN: begin
          if (abort_i) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
          end else if (lead) begin
            half_q <= 1'b1;
            if (cpha_i) mosi_q <= cur_q[bit_pos(idx_q, len_m1_i, lsb_i)];
          end else if (trail) begin
            half_q <= 1'b0;
            if (last_bit) begin
              rx_push_o <= 1'b1;
              rx_word_o <= rx_next;
              if (last_q) begin
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end else if (!tx_valid_i) begin
                unf_o   <= 1'b1;
                state_q <= ST_IDLE;
              end
            end else begin
              idx_q <= LEN_W'(idx_q + LEN_W'(1));
              if (!cpha_i)
                mosi_q <= cur_q[bit_pos(LEN_W'(idx_q + LEN_W'(1)), len_m1_i, lsb_i)];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_idle_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (sclk_o == cpol_i));
  assert_stop_on_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));
  assert_single_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, unf_o}));
  assert_no_edge_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !tx_pop_o) |=> !half_q);
endmodule

// File: rtl/spi_eng_events.sv
module spi_eng_events #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] ev_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] ev_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '1;
    end else begin
      ev_q <= (ev_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;
  assign irq_o  = |(ev_q & ~mask_q);

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & $past(clr_i & ~set_i)) == '0));
  assert_set_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & $past(set_i)) == $past(set_i)));
  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  input  logic              sclk_tick_i,
  input  logic              mm_fault_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned CW    = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(3);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W - 1);

  cfg_t cfg_q, cfg_wr;
  logic wr_data, wr_cfg, wr_cmd, wr_ev, wr_mask, rd_data;
  logic cmd_start, cmd_rx_clr, cmd_tx_clr;

  logic [DATA_W:0]   tx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head, rx_word;
  logic              tx_pop, rx_push, sh_done, sh_unf, sh_busy;
  logic [CW-1:0]     tx_thr, rx_thr;
  logic [EV_N-1:0]   ev_set, ev_clr, ev, mask;
  logic              unused_wdata;

  assign wr_data = reg_we_i && (reg_addr_i == A_DATA);
  assign wr_cfg  = reg_we_i && (reg_addr_i == A_CFG);
  assign wr_cmd  = reg_we_i && (reg_addr_i == A_CMD);
  assign wr_ev   = reg_we_i && (reg_addr_i == A_EVENT);
  assign wr_mask = reg_we_i && (reg_addr_i == A_MASK);
  assign rd_data = reg_re_i && (reg_addr_i == A_DATA);

  assign cmd_start  = wr_cmd && reg_wdata_i[0];
  assign cmd_rx_clr = wr_cmd && reg_wdata_i[1];
  assign cmd_tx_clr = wr_cmd && reg_wdata_i[2];
  assign unused_wdata = ^reg_wdata_i[BUS_W-1:DATA_W+1];

  always_comb begin
    cfg_wr = cfg_t'(reg_wdata_i[CFG_W-1:0]);
    if (cfg_wr.len_m1 < LEN_MIN) cfg_wr.len_m1 = LEN_MIN;
    if (cfg_wr.len_m1 > LEN_MAX) cfg_wr.len_m1 = LEN_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q        <= '0;
      cfg_q.len_m1 <= LEN_W'(7);
      cfg_q.tx_thr <= 2'd3;
      cfg_q.rx_thr <= 2'd3;
    end else if (wr_cfg) begin
      cfg_q <= cfg_wr;
    end
  end

  spi_eng_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(cmd_tx_clr),
    .push_i(wr_data), .data_i(reg_wdata_i[DATA_W:0]),
    .pop_i(tx_pop), .data_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty));

  spi_eng_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(cmd_rx_clr),
    .push_i(rx_push), .data_i(rx_word),
    .pop_i(rd_data), .data_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty));

  spi_eng_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni, .tick_i(sclk_tick_i), .start_i(cmd_start),
    .abort_i(mm_fault_i), .enable_i(cfg_q.en), .len_m1_i(cfg_q.len_m1),
    .lsb_i(cfg_q.lsb), .cpol_i(cfg_q.cpol), .cpha_i(cfg_q.cpha),
    .loop_i(cfg_q.loop), .tx_valid_i(!tx_empty),
    .tx_word_i(tx_head[DATA_W-1:0]), .tx_last_i(tx_head[DATA_W]),
    .miso_i, .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .done_o(sh_done), .unf_o(sh_unf), .busy_o(sh_busy),
    .sclk_o, .mosi_o);

  assign tx_thr = CW'(1) << cfg_q.tx_thr;
  assign rx_thr = CW'(1) << cfg_q.rx_thr;

  always_comb begin
    ev_set            = '0;
    ev_set[EV_DONE]   = sh_done;
    ev_set[EV_RX_REQ] = cfg_q.en && (rx_cnt >= rx_thr);
    ev_set[EV_TX_REQ] = cfg_q.en && ((CW'(FIFO_DEPTH) - tx_cnt) >= tx_thr);
    ev_set[EV_RX_OVF] = rx_push && rx_full;
    ev_set[EV_RX_UNF] = rd_data && rx_empty;
    ev_set[EV_TX_OVF] = wr_data && tx_full;
    ev_set[EV_TX_UNF] = sh_unf;
    ev_set[EV_MM]     = mm_fault_i && sh_busy;
  end
  assign ev_clr = wr_ev ? reg_wdata_i[EV_N-1:0] : '0;

  spi_eng_events #(.N(EV_N)) u_events (
    .clk_i, .rst_ni, .set_i(ev_set), .clr_i(ev_clr),
    .mask_we_i(wr_mask), .mask_i(reg_wdata_i[EV_N-1:0]),
    .ev_o(ev), .mask_o(mask), .irq_o);

  always_comb begin
    unique case (reg_addr_i)
      A_DATA:  reg_rdata_o = BUS_W'(rx_head);
      A_CFG:   reg_rdata_o = BUS_W'(cfg_q);
      A_STAT:  reg_rdata_o = BUS_W'({sh_busy, rx_empty, tx_full, cfg_q.en});
      A_EVENT: reg_rdata_o = BUS_W'(ev);
      A_MASK:  reg_rdata_o = BUS_W'(mask);
      default: reg_rdata_o = '0;
    endcase
  end

  assert_ovf_only_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !rd_data && !cmd_rx_clr) |=> (rx_cnt == CW'(FIFO_DEPTH)));
  assert_start_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.en && !sh_busy) |=> !sh_busy);
  assert_len_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.len_m1 >= LEN_MIN) && (cfg_q.len_m1 <= LEN_MAX));
  assert_mm_abort_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_fault_i |=> !sh_busy);
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq, sclk, mosi;
  logic        miso = 1'b0, tick = 1'b0, mm = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0, tog = 0, bit_err = 0;
  bit finished = 1'b0, cap_en = 1'b0;
  int cur_len = 8;
  logic cur_lsb = 0, cur_cpol = 0, cur_cpha = 0, cur_loop = 0;
  logic [31:0] exp_rx[$];
  logic        exp_bits[$];

  spi_fifo_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_re_i(re), .reg_rdata_o(rdata), .irq_o(irq),
    .sclk_tick_i(tick), .mm_fault_i(mm), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso));

  always #4 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog got %0d exp <150000", cyc);
      summary();
    end
  end

  // bit-level scoreboard: pops expected MOSI bits on the slave sampling edge
  always @(sclk) begin
    tog++;
    if (cap_en && sclk == (cur_cpha ? cur_cpol : !cur_cpol)) begin
      if (exp_bits.size() == 0) bit_err++;
      else if (exp_bits.pop_front() !== mosi) bit_err++;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1; #1 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic set_cfg(input int len, input logic lsb, input logic cpol,
                         input logic cpha, input logic loop, input logic [1:0] rxs,
                         input logic [1:0] txs);
    cur_len = len; cur_lsb = lsb; cur_cpol = cpol; cur_cpha = cpha; cur_loop = loop;
    wr(3'd1, {18'd0, 1'b1, rxs, txs, loop, cpha, cpol, lsb, 5'(len - 1)});
  endtask

  task automatic push_word(input logic [23:0] w, input logic last, input logic keep);
    logic [23:0] m;
    m = 24'((32'd1 << cur_len) - 1);
    wr(3'd0, {7'd0, last, w});
    if (keep) exp_rx.push_back({8'd0, cur_loop ? (w & m) : (miso ? m : 24'd0)});
    for (int i = 0; i < cur_len; i++)
      exp_bits.push_back(cur_lsb ? w[i] : w[cur_len - 1 - i]);
  endtask

  task automatic wait_ev(input string req, input logic [7:0] m);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd4, v);
      if ((v[7:0] & m) != 0) break;
    end
    check(req, 32'((v[7:0] & m) != 0), 32'd1);
  endtask

  task automatic run_xfer(input string req, input logic [7:0] m);
    wr(3'd4, 32'hFF);
    cap_en = 1'b1;
    wr(3'd2, 32'd1);
    wait_ev(req, m);
    cap_en = 1'b0;
  endtask

  task automatic check_bits(input string req);
    check(req, 32'(bit_err), 32'd0);
    check(req, 32'(exp_bits.size()), 32'd0);
    bit_err = 0;
    exp_bits.delete();
  endtask

  task automatic drain(input string req);
    logic [31:0] v;
    while (exp_rx.size() != 0) begin
      rd(3'd0, v);
      check(req, v, exp_rx.pop_front());
    end
    rd(3'd3, v);
    check(req, {31'd0, v[2]}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, v); check("R1 event", v, 32'h0);
    rd(3'd5, v); check("R1 mask", v, 32'hFF);
    rd(3'd1, v); check("R1 cfg", v, 32'h1E07);
    rd(3'd3, v); check("R1 stat", v, 32'h4);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 sclk", {31'd0, sclk}, 32'd0);

    // R2 clamping of word length
    wr(3'd1, 32'h0000_0001); rd(3'd1, v); check("R2 clamp low", v & 32'h1F, 32'd3);
    wr(3'd1, 32'h0000_001F); rd(3'd1, v); check("R2 clamp high", v & 32'h1F, 32'd23);

    // R6 no shifting before start, R5/R3 MSB-first loopback mode 0
    set_cfg(8, 0, 0, 0, 1, 2'd3, 2'd3);
    rd(3'd3, v); check("R6 ready", v & 32'h1, 32'd1);
    push_word(24'hA5, 0, 1);
    push_word(24'h3C, 1, 1);
    t0 = tog;
    repeat (40) @(negedge clk);
    check("R6 no sclk before start", 32'(tog - t0), 32'd0);
    rd(3'd3, v); check("R6 rx empty before start", v & 32'hC, 32'h4);
    run_xfer("R5 done", 8'h01);
    check("R5 sclk idle", {31'd0, sclk}, 32'd0);
    rd(3'd3, v); check("R5 not busy", v & 32'h8, 32'd0);
    check_bits("R3 msb order");
    drain("R5 rx data");

    // R4/R3/R11 mode 3, LSB first, 12-bit loopback with miso tied high
    miso = 1'b1;
    set_cfg(12, 1, 1, 1, 1, 2'd3, 2'd3);
    check("R4 cpol idle high", {31'd0, sclk}, 32'd1);
    push_word(24'h5A3, 0, 1);
    push_word(24'h0F1, 1, 1);
    run_xfer("R4 mode3 done", 8'h01);
    check_bits("R4 mode3 bits");
    drain("R11 loopback ignores miso");

    // R4 mode 1 and mode 2, external miso
    set_cfg(8, 0, 0, 1, 0, 2'd3, 2'd3);
    push_word(24'h5A, 1, 1);
    run_xfer("R4 mode1 done", 8'h01);
    check_bits("R4 mode1 bits");
    drain("R4 mode1 rx");
    set_cfg(8, 1, 1, 0, 0, 2'd3, 2'd3);
    push_word(24'hC3, 1, 1);
    run_xfer("R4 mode2 done", 8'h01);
    check_bits("R3 lsb mode2 bits");
    drain("R4 mode2 rx");

    // R2 length extremes
    miso = 1'b0;
    set_cfg(4, 0, 0, 0, 0, 2'd3, 2'd3);
    push_word(24'h9, 1, 1);
    run_xfer("R2 len4 done", 8'h01);
    check_bits("R2 len4 bits");
    drain("R2 len4 rx");
    miso = 1'b1;
    set_cfg(24, 0, 1, 1, 0, 2'd3, 2'd3);
    push_word(24'h81C3E7, 1, 1);
    run_xfer("R2 len24 done", 8'h01);
    check_bits("R2 len24 bits");
    drain("R2 len24 zero-extended");

    // R8 write-one-to-clear, condition still present re-sets tx request
    wr(3'd4, 32'hFF); rd(3'd4, v); check("R8 w1c", v, 32'h04);

    // R9 masking
    set_cfg(8, 0, 0, 0, 1, 2'd3, 2'd3);
    push_word(24'h11, 1, 1);
    run_xfer("R9 done", 8'h01);
    check_bits("R9 bits");
    drain("R9 rx");
    check("R9 masked irq", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'hFE); check("R9 unmasked irq", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h01); check("R9 cleared irq", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'hFF);

    // R7 underflow pause and resume
    push_word(24'h6B, 0, 1);
    run_xfer("R7 underflow event", 8'h40);
    t0 = tog;
    repeat (40) @(negedge clk);
    check("R7 paused sclk", 32'(tog - t0), 32'd0);
    check_bits("R7 first word bits");
    push_word(24'hD2, 1, 1);
    run_xfer("R7 resume done", 8'h01);
    check_bits("R7 resume bits");
    drain("R7 rx");

    // R10 receive overflow discards the 17th word
    for (int i = 0; i < 16; i++) push_word(24'(i * 7 + 1), 0, 1);
    wr(3'd4, 32'hFF);
    cap_en = 1'b1;
    wr(3'd2, 32'd1);
    push_word(24'hEE, 1, 0);
    wait_ev("R10 done", 8'h01);
    cap_en = 1'b0;
    rd(3'd4, v); check("R10 overflow event", v & 32'h08, 32'h08);
    check_bits("R10 bits");
    drain("R10 kept words");

    // R13 thresholds
    set_cfg(8, 0, 0, 0, 1, 2'd1, 2'd3);
    push_word(24'h21, 1, 1);
    run_xfer("R13 first", 8'h01);
    wr(3'd4, 32'hFF); rd(3'd4, v); check("R13 rx below thr", v & 32'h02, 32'h0);
    push_word(24'h22, 1, 1);
    run_xfer("R13 second", 8'h01);
    rd(3'd4, v); check("R13 rx at thr", v & 32'h02, 32'h02);
    check_bits("R13 bits");
    drain("R13 rx");
    for (int i = 0; i < 9; i++) wr(3'd0, 32'h0000_0055);
    wr(3'd4, 32'hFF); rd(3'd4, v); check("R13 tx below thr", v & 32'h04, 32'h0);

    // R12 clears and status
    wr(3'd2, 32'd4);
    rd(3'd4, v); check("R13 tx at thr", v & 32'h04, 32'h04);
    for (int i = 0; i < 16; i++) wr(3'd0, 32'h0000_0033);
    rd(3'd3, v); check("R12 tx full", v & 32'h2, 32'h2);
    // R14 push to full
    wr(3'd4, 32'hFF);
    wr(3'd0, 32'h0000_0044);
    rd(3'd4, v); check("R14 tx overflow", v & 32'h20, 32'h20);
    wr(3'd2, 32'd4);
    rd(3'd3, v); check("R12 tx cleared", v & 32'h2, 32'h0);
    wr(3'd4, 32'hFF);
    wr(3'd2, 32'd1);
    rd(3'd4, v); check("R7 start on empty", v & 32'h40, 32'h40);
    // R12 rx clear
    push_word(24'h77, 1, 0);
    run_xfer("R12 fill rx", 8'h01);
    exp_bits.delete(); bit_err = 0;
    rd(3'd3, v); check("R12 rx not empty", v & 32'h4, 32'h0);
    wr(3'd2, 32'd2);
    rd(3'd3, v); check("R12 rx cleared", v & 32'h4, 32'h4);
    // R14 read of empty rx
    wr(3'd4, 32'hFF);
    rd(3'd0, v);
    rd(3'd4, v); check("R14 rx underflow", v & 32'h10, 32'h10);
    // R14 multi-master fault
    wr(3'd0, 32'h0000_00AA);
    wr(3'd0, 32'h0100_00BB);
    wr(3'd4, 32'hFF);
    wr(3'd2, 32'd1);
    repeat (10) @(negedge clk);
    mm = 1'b1;
    @(negedge clk);
    mm = 1'b0;
    rd(3'd3, v); check("R14 mm idle", v & 32'h8, 32'h0);
    rd(3'd4, v); check("R14 mm event", v & 32'h80, 32'h80);
    check("R14 mm sclk idle", {31'd0, sclk}, 32'd0);
    wr(3'd2, 32'd6);

    finished = 1'b1;
    summary();
  end
endmodule